// File: doc/BRIEF.md
# Double-Buffered Disk Read DMA Engine

This block is the read-direction data path of a disk DMA controller. Each time the disk controller signals a data request, the engine takes one byte from the controller's data register. It packs the bytes into one of two 16-byte staging buffers that take turns. When a buffer fills, the engine raises a bus request toward the system arbiter. When the grant arrives, it copies the full buffers into memory as big-endian 16-bit words, at an address that steps up after every word.

The register block supplies the remaining byte count and receives a one-cycle strobe for each byte taken. It also loads the transfer address and can pulse a direction-change clear. One grant empties the older buffer, then the newer one if that is also full, and ends with a completion pulse that reports 0, 8 or 16 words. If both buffers are full at the same moment, a sticky overrun flag is raised.

Top module: `dma_pingpong_rx`

## Requirements
- R1: A byte is taken in a cycle only when `drq`, `src_fdc` and a nonzero `byte_count` are all high in that cycle. `cnt_dec` is high in exactly those cycles, so the register block decrements once per byte. A cycle in which any of the three is low stores nothing.
- R2: Bytes fill the active buffer in arrival order. In each memory word, the byte at the even position is bits 15:8 and the byte that follows it is bits 7:0.
- R3: Storing the 16th byte marks the active buffer full. If the other buffer is empty, filling continues in the other buffer from position 0.
- R4: If the other buffer is still full when the 16th byte lands, `ovr_err` rises and stays high until `dir_clr` or reset. Further bytes are still acknowledged on `cnt_dec` but are discarded.
- R5: `bus_req` rises in the cycle after a buffer becomes full. It falls in the cycle after `bus_grant` is sampled high.
- R6: A grant that finds the older buffer not full writes nothing, and pulses `xfer_done` with `xfer_words` = 0 in the next cycle.
- R7: Otherwise the older buffer is written as 8 words, one per clock. If the newer buffer is full at that point, its 8 words follow at once. `xfer_done` pulses together with the last write, with `xfer_words` = 8 or 16. Flushed buffers become empty.
- R8: Each word advances the address by 2. An address load discards bit 0 of the loaded value.
- R9: A word whose address is at or above `MEM_BYTES` produces no `mem_we`, but the address still advances.
- R10: `dir_clr` empties both buffers, resets the fill position and clears `ovr_err`, so that a following grant moves 0 words.
- R11: After reset, `bus_req`, `mem_we`, `xfer_done` and `ovr_err` are low and `cur_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_clr | input | 1 | Direction-change clear pulse from the register block |
| drq | input | 1 | Data request from the disk controller |
| src_fdc | input | 1 | Floppy controller selected as request source |
| fdc_data | input | 8 | Disk controller data register value |
| byte_count | input | CW | Remaining byte count from the register block |
| cnt_dec | output | 1 | Byte taken; decrement the count |
| addr_ld | input | 1 | Load the transfer address |
| addr_ld_val | input | AW | Address value to load (bit 0 ignored) |
| cur_addr | output | AW | Current transfer address |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | System bus grant |
| mem_we | output | 1 | Memory word write enable |
| mem_addr | output | AW | Memory byte address of the word |
| mem_wdata | output | 16 | Memory word data |
| xfer_done | output | 1 | Grant handling finished, bus released |
| xfer_words | output | 5 | Words moved by the last grant |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
The bench builds the engine with 16-byte buffers, a 12-bit address, a 10-bit count and `MEM_BYTES` = 64. The small memory limit lets a single 8-word flush started at 0x38 cross the boundary, so both written and suppressed words occur in one transfer. The short count puts count exhaustion partway through a buffer within a few cycles. Three back-to-back buffer loads reach the overrun path, and the test confirms that the third load is dropped while the first two come out in order.

// File: rtl/dma_pp_pkg.sv
package dma_pp_pkg;
  typedef enum logic {
    FL_IDLE = 1'b0,
    FL_RUN  = 1'b1
  } fl_state_t;
endpackage

// File: rtl/pp_buf_ram.sv
module pp_buf_ram #(
  parameter int WORDS = 16,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          hi_lane,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wbyte,
  input  logic [IW-1:0] raddr,
  output logic [15:0]   rdata
);
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we && hi_lane)  mem[waddr][15:8] <= wbyte;
    if (we && !hi_lane) mem[waddr][7:0]  <= wbyte;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_fill_ctl.sv
module pp_fill_ctl #(
  parameter int BUF_BYTES = 16,
  parameter int CW = 16,
  localparam int WPB = BUF_BYTES / 2,
  localparam int WIW = $clog2(WPB),
  localparam int PW  = $clog2(BUF_BYTES) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_clr,
  input  logic          drq,
  input  logic          src_fdc,
  input  logic [7:0]    data,
  input  logic [CW-1:0] byte_count,
  output logic          cnt_dec,
  output logic          ram_we,
  output logic          ram_hi,
  output logic [WIW:0]  ram_waddr,
  output logic [7:0]    ram_wbyte,
  input  logic          clr_valid,
  input  logic          clr_idx,
  input  logic          clr_pos,
  output logic [1:0]    full,
  output logic          act,
  output logic          fill_evt,
  output logic          ovr_err
);
  localparam logic [PW-1:0] FULLP = PW'(BUF_BYTES);
  localparam logic [PW-1:0] LASTP = PW'(BUF_BYTES - 1);

  logic [PW-1:0] pos;
  logic          take;
  logic          store;

  assign take      = drq && src_fdc && (byte_count != '0);
  assign store     = take && (pos < FULLP);
  assign cnt_dec   = take;
  assign ram_we    = store;
  assign ram_hi    = ~pos[0];
  assign ram_waddr = {act, pos[WIW:1]};
  assign ram_wbyte = data;
  assign fill_evt  = store && (pos == LASTP);

  always_ff @(posedge clk) begin
    if (rst || dir_clr) begin
      pos     <= '0;
      act     <= 1'b0;
      full    <= 2'b00;
      ovr_err <= 1'b0;
    end else begin
      if (clr_valid) full[clr_idx] <= 1'b0;
      if (clr_pos)   pos <= '0;
      if (store) begin
        if (pos == LASTP) begin
          full[act] <= 1'b1;
          if (!full[~act]) begin
            act <= ~act;
            pos <= '0;
          end else begin
            ovr_err <= 1'b1;
            pos     <= pos + PW'(1);
          end
        end else begin
          pos <= pos + PW'(1);
        end
      end
    end
  end

  // R4: overrun flag holds until cleared
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr_err && !dir_clr) |=> ovr_err);
  // R4: completing a buffer while the other is full raises the flag
  a_r4_err_on_double: assert property (@(posedge clk) disable iff (rst)
    (fill_evt && full[~act] && !clr_valid && !dir_clr) |=> ovr_err);
  // R3: position never passes one buffer length
  a_r3_pos_bound: assert property (@(posedge clk) disable iff (rst)
    pos <= FULLP);
  // R10: clear leaves both buffers empty
  a_r10_clear_empty: assert property (@(posedge clk) disable iff (rst)
    dir_clr |=> (full == 2'b00 && !ovr_err));
endmodule

// File: rtl/pp_flush_ctl.sv
module pp_flush_ctl
  import dma_pp_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int AW = 24,
  parameter int MEM_BYTES = 1 << 20,
  localparam int WPB = BUF_BYTES / 2,
  localparam int WIW = $clog2(WPB),
  localparam int WW  = $clog2(2 * WPB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_grant,
  input  logic          fill_evt,
  input  logic [1:0]    full,
  input  logic          act,
  input  logic          addr_ld,
  input  logic [AW-1:0] addr_ld_val,
  output logic          bus_req,
  output logic [WIW:0]  ram_raddr,
  input  logic [15:0]   ram_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  output logic          xfer_done,
  output logic [WW-1:0] xfer_words,
  output logic          clr_valid,
  output logic          clr_idx,
  output logic          clr_pos,
  output logic [AW-1:0] cur_addr
);
  localparam logic [WIW-1:0] KLAST = WIW'(WPB - 1);

  fl_state_t    st;
  logic         buf_sel;
  logic         phase;
  logic [WIW-1:0] k;
  logic         last;
  logic         in_range;

  assign last      = (st == FL_RUN) && (k == KLAST);
  assign clr_valid = last;
  assign clr_idx   = buf_sel;
  assign clr_pos   = last && phase;
  assign ram_raddr = {buf_sel, k};
  assign mem_wdata = ram_rdata;
  assign in_range  = 32'(cur_addr) < MEM_BYTES;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= FL_IDLE;
      buf_sel    <= 1'b0;
      phase      <= 1'b0;
      k          <= '0;
      bus_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      xfer_done  <= 1'b0;
      xfer_words <= '0;
      cur_addr   <= '0;
    end else begin
      bus_req   <= fill_evt || (bus_req && !bus_grant);
      mem_we    <= 1'b0;
      xfer_done <= 1'b0;
      if (st == FL_RUN) begin
        mem_we   <= in_range;
        mem_addr <= cur_addr;
        cur_addr <= cur_addr + AW'(2);
        k        <= k + WIW'(1);
        if (k == KLAST) begin
          if (!phase && full[act] && (act != buf_sel)) begin
            buf_sel <= act;
            phase   <= 1'b1;
            k       <= '0;
          end else begin
            st         <= FL_IDLE;
            xfer_done  <= 1'b1;
            xfer_words <= phase ? WW'(2 * WPB) : WW'(WPB);
          end
        end
      end else if (bus_grant) begin
        if (full[~act]) begin
          st      <= FL_RUN;
          buf_sel <= ~act;
          phase   <= 1'b0;
          k       <= '0;
        end else begin
          xfer_done  <= 1'b1;
          xfer_words <= '0;
        end
      end
      if (addr_ld) cur_addr <= {addr_ld_val[AW-1:1], 1'b0};
    end
  end

  // R5: request drops after a grant unless a buffer just filled
  a_r5_req_drop: assert property (@(posedge clk) disable iff (rst)
    (bus_grant && !fill_evt) |=> !bus_req);
  // R5: a newly full buffer requests the bus
  a_r5_req_rise: assert property (@(posedge clk) disable iff (rst)
    fill_evt |=> bus_req);
  // R8: address steps by one word per written slot
  a_r8_addr_step: assert property (@(posedge clk) disable iff (rst)
    (st == FL_RUN && !addr_ld) |=> cur_addr == $past(cur_addr) + AW'(2));
  // R9: no write lands outside memory
  a_r9_in_range: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> 32'(mem_addr) < MEM_BYTES);
  // R7: reported count is 0, one buffer or two
  a_r7_count_legal: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (xfer_words == '0 || xfer_words == WW'(WPB) || xfer_words == WW'(2 * WPB)));
endmodule

// File: rtl/dma_pingpong_rx.sv
module dma_pingpong_rx #(
  parameter int BUF_BYTES = 16,
  parameter int AW = 24,
  parameter int CW = 16,
  parameter int MEM_BYTES = 1 << 20,
  localparam int WPB = BUF_BYTES / 2,
  localparam int WIW = $clog2(WPB),
  localparam int WW  = $clog2(2 * WPB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_clr,
  input  logic          drq,
  input  logic          src_fdc,
  input  logic [7:0]    fdc_data,
  input  logic [CW-1:0] byte_count,
  output logic          cnt_dec,
  input  logic          addr_ld,
  input  logic [AW-1:0] addr_ld_val,
  output logic [AW-1:0] cur_addr,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  output logic          xfer_done,
  output logic [WW-1:0] xfer_words,
  output logic          ovr_err
);
  logic         ram_we, ram_hi;
  logic [WIW:0] ram_waddr, ram_raddr;
  logic [7:0]   ram_wbyte;
  logic [15:0]  ram_rdata;
  logic         clr_valid, clr_idx, clr_pos;
  logic [1:0]   full;
  logic         act, fill_evt;

  pp_buf_ram #(.WORDS(2 * WPB)) u_ram (
    .clk(clk), .we(ram_we), .hi_lane(ram_hi), .waddr(ram_waddr),
    .wbyte(ram_wbyte), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  pp_fill_ctl #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_fill (
    .clk(clk), .rst(rst), .dir_clr(dir_clr), .drq(drq), .src_fdc(src_fdc),
    .data(fdc_data), .byte_count(byte_count), .cnt_dec(cnt_dec),
    .ram_we(ram_we), .ram_hi(ram_hi), .ram_waddr(ram_waddr), .ram_wbyte(ram_wbyte),
    .clr_valid(clr_valid), .clr_idx(clr_idx), .clr_pos(clr_pos),
    .full(full), .act(act), .fill_evt(fill_evt), .ovr_err(ovr_err)
  );

  pp_flush_ctl #(.BUF_BYTES(BUF_BYTES), .AW(AW), .MEM_BYTES(MEM_BYTES)) u_flush (
    .clk(clk), .rst(rst), .bus_grant(bus_grant), .fill_evt(fill_evt),
    .full(full), .act(act), .addr_ld(addr_ld), .addr_ld_val(addr_ld_val),
    .bus_req(bus_req), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .xfer_done(xfer_done), .xfer_words(xfer_words),
    .clr_valid(clr_valid), .clr_idx(clr_idx), .clr_pos(clr_pos),
    .cur_addr(cur_addr)
  );
endmodule

// File: tb/test_dma_pingpong_rx.sv
module test_dma_pingpong_rx;
  localparam int BB = 16;
  localparam int AW = 12;
  localparam int CW = 10;
  localparam int MB = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dir_clr = 1'b0;
  logic          drq = 1'b0;
  logic          src_fdc = 1'b1;
  logic [7:0]    fdc_data = '0;
  logic [CW-1:0] bc = '0;
  logic          cnt_dec;
  logic          addr_ld = 1'b0;
  logic [AW-1:0] addr_ld_val = '0;
  logic [AW-1:0] cur_addr;
  logic          bus_req;
  logic          bus_grant = 1'b0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic          xfer_done;
  logic [4:0]    xfer_words;
  logic          ovr_err;

  int checks = 0;
  int fails = 0;
  int dec_seen = 0;
  bit finished = 0;
  logic [AW+15:0] sb_q[$];

  always #2 clk = ~clk;

  dma_pingpong_rx #(.BUF_BYTES(BB), .AW(AW), .CW(CW), .MEM_BYTES(MB)) i_dma_pingpong_rx (
    .clk(clk), .rst(rst), .dir_clr(dir_clr), .drq(drq), .src_fdc(src_fdc),
    .fdc_data(fdc_data), .byte_count(bc), .cnt_dec(cnt_dec),
    .addr_ld(addr_ld), .addr_ld_val(addr_ld_val), .cur_addr(cur_addr),
    .bus_req(bus_req), .bus_grant(bus_grant), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .xfer_done(xfer_done),
    .xfer_words(xfer_words), .ovr_err(ovr_err)
  );

  task automatic chk(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  // monitor: compares each memory write with the scoreboard head
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (sb_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 actual=%0h expected=%0h (unexpected write)", mem_addr, 0);
      end else begin
        logic [AW+15:0] e;
        e = sb_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R2 R7 R8 word", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic push(input logic [7:0] v, input logic src);
    bit d;
    @(negedge clk);
    drq = 1'b1; src_fdc = src; fdc_data = v;
    #1 d = cnt_dec;
    @(posedge clk);
    #1;
    if (d) begin bc = bc - 1'b1; dec_seen++; end
    drq = 1'b0; src_fdc = 1'b1;
  endtask

  task automatic fill(input int base, input int n);
    for (int i = 0; i < n; i++) push(8'(base + i), 1'b1);
  endtask

  task automatic expect_block(input int base, input int nwords, input int addr);
    for (int j = 0; j < nwords; j++) begin
      int a;
      a = addr + 2 * j;
      if (a < MB) sb_q.push_back({AW'(a), 8'(base + 2 * j), 8'(base + 2 * j + 1)});
    end
  endtask

  task automatic load_addr(input int a);
    @(negedge clk); addr_ld = 1'b1; addr_ld_val = AW'(a);
    @(negedge clk); addr_ld = 1'b0;
  endtask

  task automatic grant(input int exp_words, input string req);
    int n;
    @(negedge clk); bus_grant = 1'b1;
    @(negedge clk); bus_grant = 1'b0;
    chk(bus_req == 1'b0, "R5 req drop", bus_req, 0);
    n = 0;
    while (!xfer_done && n < 40) begin @(negedge clk); n++; end
    chk(xfer_done == 1'b1, req, xfer_done, 1);
    chk(xfer_words == 5'(exp_words), req, xfer_words, exp_words);
    @(negedge clk);
    chk(sb_q.size() == 0, req, sb_q.size(), 0);
  endtask

  task automatic pulse_clear();
    @(negedge clk); dir_clr = 1'b1;
    @(negedge clk); dir_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!bus_req && !mem_we && !xfer_done && !ovr_err, "R11 flags", {bus_req, mem_we, xfer_done, ovr_err}, 0);
    chk(cur_addr == '0, "R11 addr", cur_addr, 0);

    // R1 gating: wrong source, then zero count
    bc = 10'd200;
    push(8'hEE, 1'b0);
    chk(dec_seen == 0, "R1 source gate", dec_seen, 0);
    bc = 10'd0;
    push(8'hEE, 1'b1);
    chk(dec_seen == 0, "R1 zero count", dec_seen, 0);
    bc = 10'd200;

    // R8 load drops bit 0, R3/R5 single buffer
    load_addr(12'h011);
    chk(cur_addr == 12'h010, "R8 load", cur_addr, 12'h010);
    fill(8'hA0, 15);
    chk(bus_req == 1'b0, "R1 R5 no early req", bus_req, 0);
    fill(8'hAF, 1);
    chk(bus_req == 1'b1, "R5 req rise", bus_req, 1);
    chk(dec_seen == 16, "R1 dec count", dec_seen, 16);
    expect_block(8'hA0, 8, 12'h010);
    grant(8, "R7 one buffer");
    chk(cur_addr == 12'h020, "R8 advance", cur_addr, 12'h020);
    chk(ovr_err == 1'b0, "R3 no err", ovr_err, 0);

    // R6 empty grant
    grant(0, "R6 nothing full");
    chk(cur_addr == 12'h020, "R6 addr held", cur_addr, 12'h020);

    // R4/R7 both buffers
    fill(8'h40, 32);
    chk(ovr_err == 1'b1, "R4 err both full", ovr_err, 1);
    expect_block(8'h40, 16, 12'h020);
    grant(16, "R7 two buffers");
    chk(cur_addr == 12'h040, "R8 advance 16", cur_addr, 12'h040);
    chk(ovr_err == 1'b1, "R4 sticky", ovr_err, 1);
    pulse_clear();
    chk(ovr_err == 1'b0, "R10 err clear", ovr_err, 0);

    // R4 overflow drop: third buffer discarded but acknowledged
    load_addr(0);
    dec_seen = 0;
    fill(8'h60, 48);
    chk(dec_seen == 48, "R4 dec on drop", dec_seen, 48);
    expect_block(8'h60, 16, 0);
    grant(16, "R4 third dropped");
    pulse_clear();

    // R9 boundary crossing
    load_addr(12'h038);
    fill(8'h80, 16);
    expect_block(8'h80, 8, 12'h038);
    grant(8, "R9 suppress");
    chk(cur_addr == 12'h048, "R9 addr advances", cur_addr, 12'h048);

    // R10 clear discards full buffer
    fill(8'h10, 16);
    pulse_clear();
    grant(0, "R10 cleared grant");

    // R1 count exhaustion mid-buffer
    load_addr(0);
    bc = 10'd5;
    dec_seen = 0;
    fill(8'hC0, 16);
    chk(dec_seen == 5, "R1 count stops", dec_seen, 5);
    chk(bus_req == 1'b0, "R1 partial no req", bus_req, 0);
    bc = 10'd100;
    fill(8'hC5, 11);
    chk(bus_req == 1'b1, "R3 req after refill", bus_req, 1);
    expect_block(8'hC0, 8, 0);
    grant(8, "R2 resumed order");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule